// File: doc/BRIEF.md
# Word-Serial Montgomery Reduction Unit

This unit takes a double-width product `p` of two residues, an odd modulus `N` of `DIGITS` digits of `DBITS` bits each, and the one-digit constant `N'0 = -N^-1 mod 2^DBITS`. It returns `p * R^-1 mod N`, where `R = 2^(DIGITS*DBITS)`. The product and the constant come from outside the unit. So do any conversion into and out of the Montgomery domain and the computation of `N'0`.

The unit runs one reduction pass per digit of the modulus, and every pass works on digits only:

- **Quotient cycle.** One multiply-add datapath forms the quotient digit `v` from the low digit of the running partial result and `N'0`.
- **Multiply-add cycles.** The same datapath then adds `v*N`, aligned to the pass index, one modulus digit per cycle.
- **Carry cycle.** One cycle folds the last carry into the upper part of the partial result.

A multiplexer in front of the multiplier picks `N'0` in the quotient cycle and a modulus digit in the multiply-add cycles. After the last pass the upper half of the partial result is taken. One conditional subtraction of `N` then brings it below `N`.

A one-cycle `start_i` pulse latches the operands. `done_o` pulses for one cycle when `res_o` is valid. `res_o` then holds until the next result.

Top module: `mmr_reduce`

## Requirements
- R1: After reset, `done_o` is 0 and `res_o` is 0.
- R2: For an odd `N < R` and `p = x*y` with `x, y < N`, the result is `res_o = p * R^-1 mod N`, with `R = 2^(DIGITS*DBITS)`.
- R3: `done_o` rises exactly `DIGITS*DIGITS + 2*DIGITS + 1` rising edges after the edge that samples `start_i`. That is 25 edges for 4 digits.
- R4: `done_o` is high for exactly one cycle per accepted start.
- R5: Every delivered result is strictly less than `N`.
- R6: With `S = (p + V*N) / R` and `V = (-p * N^-1) mod R`, the result is `S - N` when `S >= N` and `S` otherwise. At most one subtraction is ever needed.
- R7: A `start_i` pulse while a reduction is running is ignored. The running result and its latency are unchanged.
- R8: `res_o` keeps its value between results, whatever the operand inputs do while no start is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; latches the operands when the unit is idle |
| prod_i | input | 2*DIGITS*DBITS | Double-width product to reduce |
| mod_i | input | DIGITS*DBITS | Odd modulus N |
| ninv_i | input | DBITS | Digit constant -N^-1 mod 2^DBITS |
| done_o | output | 1 | One-cycle pulse when res_o is valid |
| res_o | output | DIGITS*DBITS | Reduced result, held until the next result |

## Verification
Each result is due a fixed 25 rising edges after the start edge at four 8-bit digits: 4 passes of 6 cycles, plus one cycle for the final subtraction. The bench counts edges from the start edge and samples one time unit after each edge. It requires `done_o` at exactly that count, then samples one edge later to confirm the pulse has dropped. The expected value comes from a separate arithmetic model that computes both the modular inverse of `R` and the pre-subtraction value `S`, so the subtraction branch is checked on its own. The busy-start case puts a second pulse in the middle of the 25-edge window and still expects the first operands' result at the same edge.

// File: rtl/mmr_pkg.sv
package mmr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_QUOT  = 3'd1,
      ST_ACC   = 3'd2,
      ST_CARRY = 3'd3,
      ST_FIN   = 3'd4
   } mmr_state_e;

endpackage

// File: rtl/mmr_ctrl.sv
module mmr_ctrl
   import mmr_pkg::*;
#(
   parameter int DIGITS = 4,
   localparam int CW = $clog2(DIGITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output mmr_state_e    st_o,
   output logic [CW-1:0] iter_o,
   output logic [CW-1:0] col_o,
   output logic          load_o
);

   localparam logic [CW-1:0] LAST = CW'(DIGITS - 1);

   mmr_state_e    st_q, st_d;
   logic [CW-1:0] iter_q, iter_d;
   logic [CW-1:0] col_q, col_d;

   generate
      if (DIGITS < 2) begin : g_bad_digits
         $error("mmr_ctrl: DIGITS must be at least 2");
      end
   endgenerate

   always_comb begin
      st_d   = st_q;
      iter_d = iter_q;
      col_d  = col_q;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               st_d   = ST_QUOT;
               iter_d = '0;
            end
         end
         ST_QUOT: begin
            st_d  = ST_ACC;
            col_d = '0;
         end
         ST_ACC: begin
            if (col_q == LAST) st_d = ST_CARRY;
            else               col_d = col_q + 1'b1;
         end
         ST_CARRY: begin
            if (iter_q == LAST) begin
               st_d = ST_FIN;
            end else begin
               st_d   = ST_QUOT;
               iter_d = iter_q + 1'b1;
            end
         end
         ST_FIN:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         iter_q <= '0;
         col_q  <= '0;
      end else begin
         st_q   <= st_d;
         iter_q <= iter_d;
         col_q  <= col_d;
      end
   end

   assign st_o   = st_q;
   assign iter_o = iter_q;
   assign col_o  = col_q;
   assign load_o = (st_q == ST_IDLE) && start_i;

   // R3: a quotient cycle is always followed by a multiply-add cycle
   a_r3_quot_then_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_QUOT) |=> (st_q == ST_ACC));

   // R3: each pass starts its multiply-add cycles at column zero
   a_r3_acc_starts_col0: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_QUOT) |=> (col_q == '0));

   // R7: a start seen while busy leaves the pass counter alone
   a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ACC && start_i) |=> $stable(iter_q));

endmodule

// File: rtl/mmr_muladd.sv
module mmr_muladd #(
   parameter int DBITS = 8
) (
   input  logic [DBITS-1:0]   a_i,
   input  logic [DBITS-1:0]   m_i,
   input  logic [DBITS-1:0]   d_i,
   input  logic [DBITS-1:0]   c_i,
   output logic [2*DBITS-1:0] y_o
);

   // a*m + d + c never exceeds 2^(2*DBITS)-1, so the double-width result never overflows
   logic [2*DBITS-1:0] prod;

   generate
      if (DBITS < 2) begin : g_bad_bits
         $error("mmr_muladd: DBITS must be at least 2");
      end
   endgenerate

   always_comb begin
      prod = (2*DBITS)'(a_i) * (2*DBITS)'(m_i);
      y_o  = prod + (2*DBITS)'(d_i) + (2*DBITS)'(c_i);
   end

endmodule

// File: rtl/mmr_final_sub.sv
module mmr_final_sub #(
   parameter int NW       = 32,
   parameter int SUB_MODE = 0
) (
   input  logic [NW:0]   s_i,
   input  logic [NW-1:0] n_i,
   output logic [NW-1:0] r_o
);

   logic [NW:0] diff;
   logic        take_diff;

   assign diff = s_i - {1'b0, n_i};

   generate
      if (SUB_MODE == 0) begin : g_borrow
         assign take_diff = ~diff[NW];
      end else if (SUB_MODE == 1) begin : g_compare
         assign take_diff = (s_i >= {1'b0, n_i});
      end else begin : g_bad_mode
         $error("mmr_final_sub: SUB_MODE must be 0 or 1");
         assign take_diff = 1'b0;
      end
   endgenerate

   assign r_o = take_diff ? diff[NW-1:0] : s_i[NW-1:0];

endmodule

// File: rtl/mmr_reduce.sv
module mmr_reduce
   import mmr_pkg::*;
#(
   parameter int DIGITS   = 4,
   parameter int DBITS    = 8,
   parameter int SUB_MODE = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [2*DIGITS*DBITS-1:0] prod_i,
   input  logic [DIGITS*DBITS-1:0]   mod_i,
   input  logic [DBITS-1:0]          ninv_i,
   output logic                      done_o,
   output logic [DIGITS*DBITS-1:0]   res_o
);

   localparam int NW   = DIGITS * DBITS;
   localparam int PW   = 2 * NW;
   localparam int ND   = 2 * DIGITS + 1;
   localparam int ACCW = ND * DBITS;
   localparam int CW   = $clog2(DIGITS);
   localparam int IXW  = $clog2(ND) + 1;
   localparam int SHW  = $clog2(ACCW) + 1;

   generate
      if (DIGITS < 2 || DBITS < 2) begin : g_bad_cfg
         $error("mmr_reduce: DIGITS and DBITS must both be at least 2");
      end
   endgenerate

   mmr_state_e        st;
   logic [CW-1:0]     iter;
   logic [CW-1:0]     col;
   logic              load;

   logic [DBITS-1:0]  acc_d [ND];
   logic [ACCW-1:0]   acc_flat;
   logic [DBITS-1:0]  mod_d [DIGITS];
   logic [NW-1:0]     mod_q;
   logic [DBITS-1:0]  ninv_q;
   logic [DBITS-1:0]  v_q;
   logic [DBITS-1:0]  cy_q;
   logic [NW-1:0]     res_q;
   logic              done_q;

   logic [IXW-1:0]    dig_idx;
   logic [IXW-1:0]    car_idx;
   logic [SHW-1:0]    car_sh;
   logic [ACCW-1:0]   car_vec;
   logic [ACCW-1:0]   acc_sum;

   logic [DBITS-1:0]  mul_a, mul_m, mul_d, mul_c;
   logic [2*DBITS-1:0] mul_y;
   logic [NW:0]       s_val;
   logic [NW-1:0]     sub_out;

   mmr_ctrl #(.DIGITS(DIGITS)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .st_o    (st),
      .iter_o  (iter),
      .col_o   (col),
      .load_o  (load)
   );

   // flat views of the digit arrays
   for (genvar k = 0; k < ND; k++) begin : g_flat
      assign acc_flat[k*DBITS +: DBITS] = acc_d[k];
   end
   for (genvar k = 0; k < DIGITS; k++) begin : g_mod
      assign mod_d[k] = mod_q[k*DBITS +: DBITS];
   end

   // digit indices for the current pass
   assign dig_idx = IXW'(iter) + IXW'(col);
   assign car_idx = IXW'(iter) + IXW'(DIGITS);
   assign car_sh  = SHW'(car_idx) * SHW'(DBITS);
   assign car_vec = ACCW'(cy_q) << car_sh;
   assign acc_sum = acc_flat + car_vec;

   // operand multiplexer shared by the quotient and multiply-add cycles
   always_comb begin
      if (st == ST_QUOT) begin
         mul_a = acc_d[IXW'(iter)];
         mul_m = ninv_q;
         mul_d = '0;
         mul_c = '0;
      end else begin
         mul_a = v_q;
         mul_m = mod_d[col];
         mul_d = acc_d[dig_idx];
         mul_c = cy_q;
      end
   end

   mmr_muladd #(.DBITS(DBITS)) u_muladd (
      .a_i (mul_a),
      .m_i (mul_m),
      .d_i (mul_d),
      .c_i (mul_c),
      .y_o (mul_y)
   );

   // upper half of the partial result, one bit wider than N
   assign s_val = {acc_d[ND-1][0], acc_flat[PW-1:NW]};

   mmr_final_sub #(.NW(NW), .SUB_MODE(SUB_MODE)) u_sub (
      .s_i (s_val),
      .n_i (mod_q),
      .r_o (sub_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < ND; k++) acc_d[k] <= '0;
         mod_q  <= '0;
         ninv_q <= '0;
         v_q    <= '0;
         cy_q   <= '0;
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            for (int k = 0; k < ND; k++) begin
               acc_d[k] <= (k < 2 * DIGITS) ? prod_i[k*DBITS +: DBITS] : '0;
            end
            mod_q  <= mod_i;
            ninv_q <= ninv_i;
            cy_q   <= '0;
         end else begin
            unique case (st)
               ST_QUOT: begin
                  v_q  <= mul_y[DBITS-1:0];
                  cy_q <= '0;
               end
               ST_ACC: begin
                  acc_d[dig_idx] <= mul_y[DBITS-1:0];
                  cy_q           <= mul_y[2*DBITS-1:DBITS];
               end
               ST_CARRY: begin
                  for (int k = 0; k < ND; k++) acc_d[k] <= acc_sum[k*DBITS +: DBITS];
                  cy_q <= '0;
               end
               ST_FIN: begin
                  res_q  <= sub_out;
                  done_q <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign done_o = done_q;
   assign res_o  = res_q;

   // R2: after the multiply-add cycles, digit i of the partial result is zero
   a_r2_low_digit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CARRY) |-> (acc_d[IXW'(iter)] == '0));

   // R4: done is a single-cycle pulse
   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R5: a delivered result lies below the modulus
   a_r5_res_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (res_q < mod_q));

   // R6: the shifted value is below 2N, so its top digit holds at most one bit
   a_r6_single_sub_enough: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FIN) |-> (acc_d[ND-1][DBITS-1:1] == '0));

   // R7: the latched modulus holds for the whole reduction
   a_r7_mod_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |=> $stable(mod_q));

   // R8: the result register changes only at the end of a reduction
   a_r8_res_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_FIN) |=> $stable(res_q));

endmodule

// File: tb/mmr_reduce_bench.sv
`timescale 1ns/1ps
module mmr_reduce_bench;

   localparam int L   = 4;
   localparam int B   = 8;
   localparam int NW  = L * B;
   localparam int LAT = L * L + 2 * L + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [2*NW-1:0] prod_i = '0;
   logic [NW-1:0]   mod_i = '0;
   logic [B-1:0]    ninv_i = '0;
   logic            done_o;
   logic [NW-1:0]   res_o;

   int checks = 0;
   int failures = 0;
   int ge_seen = 0;

   always #2 clk = ~clk;

   mmr_reduce #(.DIGITS(L), .DBITS(B)) u_mmr_reduce (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .prod_i  (prod_i),
      .mod_i   (mod_i),
      .ninv_i  (ninv_i),
      .done_o  (done_o),
      .res_o   (res_o)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // inverse of an odd n modulo 2^32 by Newton iteration
   function automatic logic [31:0] inv32(input logic [31:0] n);
      logic [31:0] x = n;
      for (int k = 0; k < 5; k++) x = x * (32'd2 - n * x);
      return x;
   endfunction

   // p * 2^-32 mod n through repeated halving inverse
   function automatic logic [31:0] model_res(input logic [63:0] p, input logic [31:0] n);
      logic [127:0] half = (128'(n) + 128'd1) >> 1;
      logic [127:0] rinv = 128'd1;
      logic [127:0] m = 128'(p) % 128'(n);
      for (int k = 0; k < 32; k++) rinv = (rinv * half) % 128'(n);
      return 32'((m * rinv) % 128'(n));
   endfunction

   // value before the final subtraction
   function automatic logic [127:0] model_s(input logic [63:0] p, input logic [31:0] n);
      logic [31:0] ninv = 32'd0 - inv32(n);
      logic [31:0] v = p[31:0] * ninv;
      return (128'(p) + 128'(v) * 128'(n)) >> 32;
   endfunction

   task automatic run_op(input logic [63:0] p, input logic [31:0] n, input int poke_at,
                         output logic [31:0] got, output int lat);
      logic [31:0] ni32 = 32'd0 - inv32(n);
      @(negedge clk);
      prod_i  = p;
      mod_i   = n;
      ninv_i  = ni32[B-1:0];
      start_i = 1'b1;
      lat = 0;
      got = '0;
      for (int k = 0; k < 100; k++) begin
         @(posedge clk);
         lat++;
         #1;
         start_i = 1'b0;
         if (lat == poke_at) begin
            start_i = 1'b1;
            prod_i  = 64'h0123_4567_89AB_CDEF;
            mod_i   = 32'h0000_0101;
            ninv_i  = 8'hFF;
         end
         if (done_o) begin
            got = res_o;
            break;
         end
      end
      start_i = 1'b0;
   endtask

   task automatic full_check(input logic [31:0] x, input logic [31:0] y, input logic [31:0] n, input int poke_at);
      logic [63:0]  p = 64'(x) * 64'(y);
      logic [31:0]  exp = model_res(p, n);
      logic [127:0] s = model_s(p, n);
      logic [31:0]  got;
      int           lat;
      run_op(p, n, poke_at, got, lat);
      check(got == exp, (poke_at > 0) ? "R7 result with busy start" : "R2 reduced value", 64'(got), 64'(exp));
      check(lat == LAT + 1, (poke_at > 0) ? "R7 latency with busy start" : "R3 latency", 64'(lat), 64'(LAT + 1));
      check(got < n, "R5 result below modulus", 64'(got), 64'(n));
      if (s >= 128'(n)) begin
         ge_seen++;
         check(got == 32'(s - 128'(n)), "R6 subtracted branch", 64'(got), 64'(s - 128'(n)));
      end else begin
         check(got == 32'(s), "R6 unsubtracted branch", 64'(got), 64'(s));
      end
      @(posedge clk);
      #1;
      check(done_o == 1'b0, "R4 done drops after one cycle", 64'(done_o), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] n, x, y, held;
      repeat (3) @(posedge clk);
      #1;
      check(done_o == 1'b0, "R1 done after reset", 64'(done_o), 64'd0);
      check(res_o == '0, "R1 result after reset", 64'(res_o), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // boundary operands
      full_check(32'hFFFF_FFFD, 32'hFFFF_FFFD, 32'hFFFF_FFFF, 0);
      full_check(32'd2, 32'd2, 32'd3, 0);
      full_check(32'd0, 32'h1234_5678, 32'h8000_0001, 0);
      full_check(32'd1, 32'd1, 32'hFFFF_FFFB, 0);

      // random sweep, alternating small and large moduli
      for (int t = 0; t < 400; t++) begin
         n = $urandom() | 32'd1;
         if (t % 2 == 0) n = n | 32'h8000_0000;
         if (n < 32'd3) n = 32'd3;
         x = $urandom() % n;
         y = $urandom() % n;
         full_check(x, y, n, 0);
      end
      check(ge_seen > 0, "R6 subtraction case reached", 64'(ge_seen), 64'd1);

      // R7: second start pulse in the middle of a reduction
      full_check(32'hDEAD_BEEF, 32'h1357_9BDF, 32'hF00D_F00D, 5);
      full_check(32'h0000_1234, 32'h0000_5678, 32'h0001_0001, 13);

      // R8: result holds while operand inputs change without a start
      held = res_o;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         prod_i = {$urandom(), $urandom()};
         mod_i  = $urandom() | 32'd1;
         ninv_i = 8'($urandom());
      end
      @(posedge clk);
      #1;
      check(res_o == held, "R8 result held", 64'(res_o), 64'(held));
      check(done_o == 1'b0, "R8 no done without start", 64'(done_o), 64'd0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule